// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns bus addresses that land inside a graphics aperture into physical addresses. The aperture is described by a base address and a size code. A lookup address is first reduced to a directory slot and an entry offset. The directory slot comes from the difference between the top ten address bits of the lookup and of the base. The offset comes from address bits 21:12. The directory is a 64-slot on-chip table. Software fills it one slot at a time through a packed 32-bit load word. Each present slot names a second-level page that lives in external memory and holds 1024 four-byte page entries.

A lookup first runs a range check, then a directory check, then a probe of a small fully associative cache of recent page entries. A cache miss fetches the page entry through a request/acknowledge read port. The lookup stalls until that read is acknowledged. Software invalidates the cache by toggling one bit of a control word. A flush that arrives while a fetch is outstanding stops the fetched entry from being cached. A directory write in that window does not disturb the fetch already in flight.

Top module: `apx_translator`

## Requirements
- R1: A directory load word places the page address in bits 31:20, the present flag in bit 8 and the slot index in bits 5:0. Bits 19:9 and 7:6 have no effect. A load with bit 8 clear marks the slot absent.
- R2: Size code 0 spans 64 directory slots, 32 spans 32, 48 spans 16 and 56 spans 8. Any other code spans none, so every lookup is out of range.
- R3: A lookup whose slot difference (lookup bits 31:22 minus base bits 31:22, modulo 1024) is at or beyond the span responds with code 1 and an address of zero. It issues no memory read.
- R4: An in-range lookup whose directory slot is absent responds with code 2 and issues no memory read. This holds even if a cached entry for that slot exists.
- R5: On a cache miss the block issues exactly one read at {page[11:0], 8'h00, offset[9:0], 2'b00}. It holds mem_req and mem_addr steady until mem_ack, and keeps lk_ready low for that whole time.
- R6: A fetched entry with bit 0 clear responds with code 3 and an address of zero. It is not cached, so repeating the lookup reads memory again.
- R7: A successful lookup responds with code 0 and an address of {entry[31:12], lookup[11:0]}. A hit, range fault or directory fault responds in the cycle after acceptance. A miss responds in the cycle after mem_ack.
- R8: The cache holds 8 entries keyed by {slot, offset}. A hit performs no memory read. Fills replace entries in round-robin order. The replacement pointer is not reset by a flush.
- R9: A control write whose bit 7 goes from 0 to 1, compared with the last written value (0 after reset), invalidates every cache entry. A control write that leaves bit 7 unchanged invalidates nothing.
- R10: If a flush occurs during an outstanding fetch, including in the cycle of mem_ack, the fetched result is still returned but is not cached. A directory write during a fetch does not change that fetch's address or result.
- R11: After reset lk_ready is 1, rsp_valid and mem_req are 0, every directory slot is absent and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ap_base | input | 32 | Aperture base address |
| ap_size | input | 8 | Aperture size code |
| dir_we | input | 1 | Directory load strobe |
| dir_wdata | input | 32 | Directory load word |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word; bit 7 is the flush toggle |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup bus address |
| lk_ready | output | 1 | Lookup accepted when high with lk_valid |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_code | output | 2 | 0 ok, 1 out of range, 2 slot absent, 3 entry invalid |
| rsp_addr | output | 32 | Translated address, zero on a fault |
| mem_req | output | 1 | Page-entry read request |
| mem_addr | output | 32 | Page-entry read address |
| mem_ack | input | 1 | Read acknowledge carrying mem_rdata |
| mem_rdata | input | 32 | Page-entry read data |

## Verification
Completion of a fetch and a cache flush can fall in the same clock cycle. The flush must win: the fetched value is returned, but it must not enter the cache. The bench provokes this by writing the control word with bit 7 low ahead of time. Its memory responder then drives the bit-7-high control write in the very cycle it raises mem_ack. The bench judges the outcome by repeating the same lookup and requiring a fresh memory read. It also checks that the earlier response still carried the fetched translation.

// File: rtl/apx_pkg.sv
package apx_pkg;

   typedef enum logic [1:0] {
      RC_OK    = 2'd0,
      RC_RANGE = 2'd1,
      RC_NODIR = 2'd2,
      RC_NOPTE = 2'd3
   } apx_rcode_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_MISS = 1'b1
   } apx_state_t;

   // directory slots covered by an aperture size code; 0 means unsupported
   function automatic logic [6:0] apx_span(input logic [7:0] code);
      case (code)
         8'd0:    apx_span = 7'd64;
         8'd32:   apx_span = 7'd32;
         8'd48:   apx_span = 7'd16;
         8'd56:   apx_span = 7'd8;
         default: apx_span = 7'd0;
      endcase
   endfunction

endpackage

// File: rtl/apx_window.sv
module apx_window
   import apx_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int PAGE_SH = 12,
   parameter int OFF_W   = 10,
   parameter int IDX_W   = 6
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [7:0]        size_code,
   input  logic [ADDR_W-1:0] addr,
   output logic              in_range,
   output logic [IDX_W-1:0]  dir_idx,
   output logic [OFF_W-1:0]  pte_off
);
   localparam int DIR_SH = PAGE_SH + OFF_W;
   localparam int DIFF_W = ADDR_W - DIR_SH;

   initial begin
      assert (DIFF_W >= 7 && DIFF_W >= IDX_W)
         else $error("apx_window: slot difference narrower than span");
   end

   logic [DIFF_W-1:0] diff;
   logic [DIFF_W-1:0] span_x;
   logic              unused_low;

   assign diff     = addr[ADDR_W-1:DIR_SH] - base[ADDR_W-1:DIR_SH];
   assign span_x   = DIFF_W'(apx_span(size_code));
   assign in_range = (diff < span_x);
   assign dir_idx  = diff[IDX_W-1:0];
   assign pte_off  = addr[DIR_SH-1:PAGE_SH];

   assign unused_low = ^{base[DIR_SH-1:0], addr[PAGE_SH-1:0]};
endmodule

// File: rtl/apx_dir.sv
module apx_dir #(
   parameter int IDX_W = 6,
   parameter int PG_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_present,
   input  logic [PG_W-1:0]  wr_page,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_present,
   output logic [PG_W-1:0]  rd_page
);
   localparam int DIR_N = 1 << IDX_W;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 8) else $error("apx_dir: IDX_W out of range");
   end

   logic [DIR_N-1:0] pres_q;
   logic [PG_W-1:0]  page_q [DIR_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pres_q <= '0;
         for (int i = 0; i < DIR_N; i++) page_q[i] <= '0;
      end else if (wr_en) begin
         pres_q[wr_idx] <= wr_present;
         page_q[wr_idx] <= wr_page;
      end
   end

   assign rd_present = pres_q[rd_idx];
   assign rd_page    = page_q[rd_idx];

   // R1: a load lands in the addressed slot
   a_r1_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_idx != $past(wr_idx)) ||
                (rd_present == $past(wr_present) && rd_page == $past(wr_page)));
endmodule

// File: rtl/apx_tcache.sv
module apx_tcache #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 16,
   parameter int DAT_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   output logic [DAT_W-1:0] hit_data,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [DAT_W-1:0] fill_data,
   input  logic             flush
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      assert (ENTRIES >= 2 && ENTRIES <= 64) else $error("apx_tcache: ENTRIES out of range");
   end

   logic [ENTRIES-1:0] val_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [DAT_W-1:0]   dat_q [ENTRIES];
   logic [PTR_W-1:0]   ptr_q;
   logic [ENTRIES-1:0] hit_vec;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = val_q[g] && (tag_q[g] == lk_tag);
   end

   always_comb begin
      hit_data = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (hit_vec[i]) hit_data = hit_data | dat_q[i];
   end
   assign hit = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= '0;
         ptr_q <= '0;
      end else if (flush) begin
         val_q <= '0;
      end else if (fill_en) begin
         val_q[ptr_q] <= 1'b1;
         ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en && !flush) begin
         tag_q[ptr_q] <= fill_tag;
         dat_q[ptr_q] <= fill_data;
      end
   end

   // R8: a tag never matches more than one entry
   a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   // R9: nothing hits right after a flush
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit);
endmodule

// File: rtl/apx_translator.sv
module apx_translator
   import apx_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int PAGE_SH   = 12,
   parameter int OFF_W     = 10,
   parameter int IDX_W     = 6,
   parameter int PG_W      = 12,
   parameter int CACHE_N   = 8,
   parameter int FLUSH_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ap_base,
   input  logic [7:0]        ap_size,
   input  logic              dir_we,
   input  logic [ADDR_W-1:0] dir_wdata,
   input  logic              ctl_we,
   input  logic [ADDR_W-1:0] ctl_wdata,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_ready,
   output logic              rsp_valid,
   output logic [1:0]        rsp_code,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata
);
   localparam int TAG_W    = IDX_W + OFF_W;
   localparam int DAT_W    = ADDR_W - PAGE_SH;
   localparam int PAD_W    = ADDR_W - PG_W - OFF_W - 2;
   localparam int PG_LO    = ADDR_W - PG_W;
   localparam int PRES_BIT = 8;

   initial begin
      assert (PAD_W >= 1) else $error("apx_translator: page fields overflow address");
      assert (PG_LO > PRES_BIT + 1 && PRES_BIT > IDX_W)
         else $error("apx_translator: load word fields overlap");
      assert (FLUSH_BIT < ADDR_W) else $error("apx_translator: flush bit outside word");
   end

   // window and directory
   logic              w_in_range;
   logic [IDX_W-1:0]  w_idx;
   logic [OFF_W-1:0]  w_off;
   logic              d_present;
   logic [PG_W-1:0]   d_page;
   logic              c_hit;
   logic [DAT_W-1:0]  c_data;

   apx_window #(.ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_win (
      .base(ap_base), .size_code(ap_size), .addr(lk_addr),
      .in_range(w_in_range), .dir_idx(w_idx), .pte_off(w_off)
   );

   apx_dir #(.IDX_W(IDX_W), .PG_W(PG_W)) u_dir (
      .clk(clk), .rst_n(rst_n),
      .wr_en(dir_we), .wr_idx(dir_wdata[IDX_W-1:0]),
      .wr_present(dir_wdata[PRES_BIT]), .wr_page(dir_wdata[ADDR_W-1:PG_LO]),
      .rd_idx(w_idx), .rd_present(d_present), .rd_page(d_page)
   );

   // control state
   apx_state_t        st_q;
   logic              ctl_bit_q;
   logic              flush_evt;
   logic              pflush_q;
   logic [ADDR_W-1:0] miss_addr_q;
   logic [PAGE_SH-1:0] lo_q;
   logic [TAG_W-1:0]  tag_q;
   logic              rsp_valid_q;
   apx_rcode_t        rsp_code_q;
   logic [ADDR_W-1:0] rsp_addr_q;
   logic              accept;
   logic              fill_en;
   logic              unused_bits;

   assign flush_evt = ctl_we && ctl_wdata[FLUSH_BIT] && !ctl_bit_q;
   assign lk_ready  = (st_q == ST_IDLE);
   assign accept    = lk_valid && lk_ready;
   assign fill_en   = (st_q == ST_MISS) && mem_ack && mem_rdata[0]
                      && !pflush_q && !flush_evt;

   apx_tcache #(.ENTRIES(CACHE_N), .TAG_W(TAG_W), .DAT_W(DAT_W)) u_cache (
      .clk(clk), .rst_n(rst_n),
      .lk_tag({w_idx, w_off}), .hit(c_hit), .hit_data(c_data),
      .fill_en(fill_en), .fill_tag(tag_q), .fill_data(mem_rdata[ADDR_W-1:PAGE_SH]),
      .flush(flush_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         ctl_bit_q   <= 1'b0;
         pflush_q    <= 1'b0;
         miss_addr_q <= '0;
         lo_q        <= '0;
         tag_q       <= '0;
         rsp_valid_q <= 1'b0;
         rsp_code_q  <= RC_OK;
         rsp_addr_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         if (ctl_we) ctl_bit_q <= ctl_wdata[FLUSH_BIT];
         case (st_q)
            ST_IDLE: begin
               if (lk_valid) begin
                  if (!w_in_range) begin
                     rsp_valid_q <= 1'b1;
                     rsp_code_q  <= RC_RANGE;
                     rsp_addr_q  <= '0;
                  end else if (!d_present) begin
                     rsp_valid_q <= 1'b1;
                     rsp_code_q  <= RC_NODIR;
                     rsp_addr_q  <= '0;
                  end else if (c_hit) begin
                     rsp_valid_q <= 1'b1;
                     rsp_code_q  <= RC_OK;
                     rsp_addr_q  <= {c_data, lk_addr[PAGE_SH-1:0]};
                  end else begin
                     st_q        <= ST_MISS;
                     miss_addr_q <= {d_page, {PAD_W{1'b0}}, w_off, 2'b00};
                     lo_q        <= lk_addr[PAGE_SH-1:0];
                     tag_q       <= {w_idx, w_off};
                     pflush_q    <= 1'b0;
                  end
               end
            end
            ST_MISS: begin
               if (flush_evt) pflush_q <= 1'b1;
               if (mem_ack) begin
                  st_q        <= ST_IDLE;
                  rsp_valid_q <= 1'b1;
                  if (mem_rdata[0]) begin
                     rsp_code_q <= RC_OK;
                     rsp_addr_q <= {mem_rdata[ADDR_W-1:PAGE_SH], lo_q};
                  end else begin
                     rsp_code_q <= RC_NOPTE;
                     rsp_addr_q <= '0;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_code  = rsp_code_q;
   assign rsp_addr  = rsp_addr_q;
   assign mem_req   = (st_q == ST_MISS);
   assign mem_addr  = miss_addr_q;

   assign unused_bits = ^{dir_wdata[PG_LO-1:PRES_BIT+1], dir_wdata[PRES_BIT-1:IDX_W],
                          ctl_wdata, mem_rdata[PAGE_SH-1:1]};

   // R3: out-of-range lookups fault without a read
   a_r3_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !w_in_range |=> rsp_valid && rsp_code == 2'd1 && !mem_req);
   // R4: absent slot faults without a read
   a_r4_absent_fault: assert property (@(posedge clk) disable iff (!rst_n)
      accept && w_in_range && !d_present |=> rsp_valid && rsp_code == 2'd2 && !mem_req);
   // R5: request held steady until acknowledged
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
   // R5: no new lookup while a read is outstanding
   a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !lk_ready);
   // R6: faults carry no address
   a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_code != 2'd0 |-> rsp_addr == '0);
   // R7: every response follows an acceptance or an acknowledge
   a_r7_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(accept) || $past(mem_req && mem_ack));
endmodule

// File: tb/sim_apx_translator.sv
module sim_apx_translator;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ap_base = BASE;
   logic [7:0]  ap_size = 8'd0;
   logic        dir_we = 1'b0;
   logic [31:0] dir_wdata = '0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_ready;
   logic        rsp_valid;
   logic [1:0]  rsp_code;
   logic [31:0] rsp_addr;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   apx_translator u0 (
      .clk(clk), .rst_n(rst_n), .ap_base(ap_base), .ap_size(ap_size),
      .dir_we(dir_we), .dir_wdata(dir_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_addr(rsp_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int total = 0;
   int bad = 0;
   int nreads = 0;
   int dly = 0;
   logic [31:0] last_maddr = '0;
   logic [31:0] salt = 32'h1357_9bdf;
   bit arm_ack_flush = 0;
   bit ack_flush_on = 0;

   // reference state
   bit          m_pres [64];
   logic [11:0] m_page [64];
   bit          c_val [8];
   logic [15:0] c_tag [8];
   logic [19:0] c_dat [8];
   int          c_ptr = 0;
   bit          ctl7 = 0;

   function automatic logic [31:0] mem_val(input logic [31:0] a, input logic [31:0] s);
      logic [31:0] h;
      h = (a ^ s) * 32'h9E37_79B1;
      return {h[31:1], (a[5:2] != 4'hF)};
   endfunction

   function automatic int span_ref(input logic [7:0] c);
      case (c)
         8'd0:    return 64;
         8'd32:   return 32;
         8'd48:   return 16;
         8'd56:   return 8;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_flush();
      for (int i = 0; i < 8; i++) c_val[i] = 0;
   endtask

   task automatic ctl_write(input logic [31:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
      if (v[7] && !ctl7) model_flush();
      ctl7 = v[7];
   endtask

   task automatic dir_write(input logic [31:0] v);
      @(negedge clk);
      dir_we = 1'b1; dir_wdata = v;
      @(negedge clk);
      dir_we = 1'b0;
      m_pres[v[5:0]] = v[8];
      m_page[v[5:0]] = v[31:20];
   endtask

   function automatic logic [31:0] ent(input logic [11:0] pg, input bit pres, input logic [5:0] idx);
      return {pg, 8'h00, 3'b000, pres, 2'b00, idx};
   endfunction

   function automatic logic [31:0] la(input int slot, input int off, input int lo);
      return BASE + (slot << 22) + (off << 12) + lo;
   endfunction

   // memory responder
   initial begin
      forever begin
         @(negedge clk);
         if (ack_flush_on) begin ctl_we = 1'b0; ack_flush_on = 0; end
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            if (dly > 0) dly--;
            else begin
               mem_ack = 1'b1;
               mem_rdata = mem_val(mem_addr, salt);
               nreads++;
               last_maddr = mem_addr;
               dly = $urandom % 3;
               if (arm_ack_flush) begin
                  ctl_we = 1'b1; ctl_wdata = 32'h0000_2280;
                  arm_ack_flush = 0; ack_flush_on = 1;
               end
            end
         end
      end
   end

   // one lookup; mid_ops: 1 flush during fetch, 2 directory rewrite during fetch
   task automatic do_look(input logic [31:0] a, input int mid_ops, input logic [11:0] new_pg,
                          input bit flush_at_ack, input string tag);
      logic [9:0]  diff;
      logic [15:0] t;
      logic [31:0] e_addr, e_maddr, v;
      int e_code, e_reads, r0, n, hit_i;
      bit nofill;
      nofill = (mid_ops != 0 && mid_ops != 2) || flush_at_ack;
      diff = a[31:22] - ap_base[31:22];
      e_addr = '0; e_maddr = '0; e_reads = 0;
      if (int'(diff) >= span_ref(ap_size)) e_code = 1;
      else if (!m_pres[diff[5:0]]) e_code = 2;
      else begin
         t = {diff[5:0], a[21:12]};
         hit_i = -1;
         for (int i = 0; i < 8; i++) if (c_val[i] && c_tag[i] == t) hit_i = i;
         if (hit_i >= 0) begin
            e_code = 0; e_addr = {c_dat[hit_i], a[11:0]};
         end else begin
            e_reads = 1;
            e_maddr = {m_page[diff[5:0]], 8'h00, a[21:12], 2'b00};
            v = mem_val(e_maddr, salt);
            if (v[0]) begin
               e_code = 0; e_addr = {v[31:12], a[11:0]};
               if (!nofill) begin
                  c_val[c_ptr] = 1; c_tag[c_ptr] = t; c_dat[c_ptr] = v[31:12];
                  c_ptr = (c_ptr + 1) % 8;
               end
            end else e_code = 3;
         end
      end
      r0 = nreads;
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_valid = 1'b0;
      n = 0;
      if (mid_ops == 1 || mid_ops == 3) begin
         ctl_write(32'h0000_2200);
         ctl_write(32'h0000_2280);
      end
      if (mid_ops >= 2) dir_write(ent(new_pg, 1'b1, diff[5:0]));
      while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
      chk(rsp_valid, {tag, " R7 response seen"}, 32'(rsp_valid), 32'd1);
      chk(int'(rsp_code) == e_code, {tag, " code R3/R4/R6/R7"}, 32'(rsp_code), 32'(e_code));
      chk(rsp_addr == e_addr, {tag, " address R7"}, rsp_addr, e_addr);
      chk(nreads - r0 == e_reads, {tag, " read count R5/R8"}, 32'(nreads - r0), 32'(e_reads));
      if (e_reads == 0 && mid_ops == 0)
         chk(n == 0, {tag, " latency R7"}, 32'(n), 32'd0);
      if (e_reads == 1 && nreads - r0 == 1)
         chk(last_maddr == e_maddr, {tag, " read address R5"}, last_maddr, e_maddr);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin m_pres[i] = 0; m_page[i] = '0; end
      for (int i = 0; i < 8; i++) c_val[i] = 0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(lk_ready == 1'b1, "R11 lk_ready in reset", 32'(lk_ready), 32'd1);
      chk(rsp_valid == 1'b0, "R11 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      chk(mem_req == 1'b0, "R11 mem_req in reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      do_look(la(0, 3, 12'h010), 0, 12'h0, 0, "R11 empty directory");
      // R1 load word with noise in ignored bits
      dir_write({12'h123, 8'hFF, 3'b111, 1'b1, 2'b11, 6'd0});
      do_look(la(0, 3, 12'h044), 0, 12'h0, 0, "R1 first fetch");
      do_look(la(0, 3, 12'h7F8), 0, 12'h0, 0, "R8 cached hit");
      do_look(la(0, 15, 12'h000), 0, 12'h0, 0, "R6 invalid entry");
      do_look(la(0, 15, 12'h000), 0, 12'h0, 0, "R6 invalid again");
      // R3 range
      do_look(la(64, 0, 0), 0, 12'h0, 0, "R3 past end");
      do_look(BASE - 32'h0040_0000, 0, 12'h0, 0, "R3 below base");
      // R2 size codes
      dir_write(ent(12'h207, 1'b1, 6'd7));
      dir_write(ent(12'h208, 1'b1, 6'd8));
      ap_size = 8'd56;
      do_look(la(7, 1, 5), 0, 12'h0, 0, "R2 code56 last");
      do_look(la(8, 1, 5), 0, 12'h0, 0, "R2 code56 over");
      ap_size = 8'd48;
      do_look(la(8, 2, 5), 0, 12'h0, 0, "R2 code48 in");
      do_look(la(16, 2, 5), 0, 12'h0, 0, "R2 code48 over");
      ap_size = 8'd32;
      do_look(la(32, 2, 5), 0, 12'h0, 0, "R2 code32 over");
      ap_size = 8'd99;
      do_look(la(0, 3, 5), 0, 12'h0, 0, "R2 bad code");
      ap_size = 8'd0;
      // R1 bare index clears slot, R4 despite cached entry
      dir_write(32'd0);
      do_look(la(0, 3, 5), 0, 12'h0, 0, "R4 absent over cache");
      // R9 flush edge
      dir_write(ent(12'h200, 1'b1, 6'd1));
      ctl_write(32'h0000_2200);
      ctl_write(32'h0000_2280);
      do_look(la(1, 5, 9), 0, 12'h0, 0, "R9 fill");
      salt = 32'hCAFE_0001;
      do_look(la(1, 5, 9), 0, 12'h0, 0, "R9 stale hit");
      ctl_write(32'h0000_2280);
      do_look(la(1, 5, 9), 0, 12'h0, 0, "R9 no edge no flush");
      ctl_write(32'h0000_2200);
      ctl_write(32'h0000_2280);
      do_look(la(1, 5, 9), 0, 12'h0, 0, "R9 refetch");
      // R8 round robin
      for (int k = 0; k < 9; k++) do_look(la(1, 32 + k, k), 0, 12'h0, 0, "R8 fill");
      do_look(la(1, 32, 0), 0, 12'h0, 0, "R8 evicted");
      do_look(la(1, 40, 0), 0, 12'h0, 0, "R8 newest");
      // R10 flush and directory write during fetch
      dir_write(ent(12'h300, 1'b1, 6'd2));
      ctl_write(32'h0000_2200);
      ctl_write(32'h0000_2280);
      dly = 12;
      do_look(la(2, 4, 3), 3, 12'h301, 0, "R10 mid flush+dir");
      do_look(la(2, 4, 3), 0, 12'h0, 0, "R10 refetch new page");
      dly = 8;
      do_look(la(2, 6, 3), 2, 12'h302, 0, "R10 mid dir only");
      do_look(la(2, 6, 3), 0, 12'h0, 0, "R10 kept old fill");
      // R10 flush in the acknowledge cycle
      ctl_write(32'h0000_2200);
      arm_ack_flush = 1;
      do_look(la(2, 9, 1), 0, 12'h0, 1, "R10 flush at ack");
      @(negedge clk);
      model_flush();
      ctl7 = 1;
      do_look(la(2, 9, 1), 0, 12'h0, 0, "R10 not cached");
      // random phase
      for (int it = 0; it < 500; it++) begin
         int op;
         op = $urandom % 100;
         if (op < 72) begin
            int s, o;
            s = $urandom % 70;
            o = $urandom % 24;
            do_look(la(s, o, $urandom % 4096), 0, 12'h0, 0, "rand");
         end else if (op < 84) begin
            dir_write(ent(12'($urandom), 1'($urandom % 4 != 0), 6'($urandom % 64)));
         end else if (op < 90) begin
            ctl_write(32'h0000_2200);
            ctl_write(32'h0000_2280);
         end else if (op < 95) begin
            salt = $urandom;
         end else begin
            case ($urandom % 4)
               0: ap_size = 8'd0;
               1: ap_size = 8'd32;
               2: ap_size = 8'd48;
               default: ap_size = 8'd56;
            endcase
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule